// File: doc/BRIEF.md
# Immediate and Carry Integer Execute Unit

This block is one registered execute stage of an integer datapath that runs 32-bit arithmetic on a 64-bit register file. Each cycle it can accept one 32-bit instruction word, the values of two source registers (64 bits each) and the current summary-overflow bit. It decodes a small group of operations: add with immediate, add with immediate and carry (plain and recording), subtract-from-immediate with carry, low-half multiply by immediate, and the register subtract-from with carry. One cycle later it presents a writeback value, a destination index and a write enable. It also presents the carry flag, the overflow and summary-overflow flags and a 4-bit condition field. Each of these outputs has its own update enable.

Every calculation and every carry compare uses only the low 32 bits of the source values. The 32-bit result is zero-extended into the 64-bit writeback. Because of this, stale upper halves in the register file cannot reach the result or any flag. A register file, fetch logic and program-counter logic surround the block, and all of them are outside it.

Top module: `imm_alu_exec`

## Requirements
- R1: Instruction bits 31:26 hold the primary opcode. The decoded values are 14 (add-immediate), 12 (add-immediate-carrying), 13 (add-immediate-carrying with record), 8 (subtract-from-immediate-carrying) and 7 (multiply-low-immediate). Primary opcode 31 is the register subtract-from-carrying only when bits 9:1 equal 8. For that form, bit 10 is the overflow-enable bit and bit 0 is the record bit. Any other encoding still produces a valid output, but wb_en, ca_en, ov_en and cr_en are all low and wb_data is zero.
- R2: Add-immediate returns the sign-extended 16-bit immediate (bits 15:0) plus the first source. When the first-source index (bits 20:16) is 0, the value zero is used in place of the register. Index 0 with immediate 0xFFFF writes 0x00000000_FFFFFFFF.
- R3: wb_data is always the 32-bit result with bits 63:32 zero. Bits 63:32 of either source never change any output. wb_idx is always bits 25:21.
- R4: Add-immediate-carrying sets ca_out when the 32-bit sum is unsigned less than the low source word. A source of 0xFFFFFFFF_00000001 with immediate 0xFFFF gives 0 with carry 1.
- R5: The recording add-immediate-carrying form (opcode 13) gives the same result and carry as opcode 12, and it also raises cr_en.
- R6: Subtract-from-immediate returns imm32 minus the low source word, with ca_out = (imm32 unsigned >= source). A source of 5 with immediate 0xFFFF gives 0x00000000_FFFFFFFA and carry 1.
- R7: Multiply-low-immediate keeps the low 32 bits of the signed product of the low source word and the immediate. 0x80000000 times 2 gives 0. This operation updates no flags.
- R8: The register subtract returns the second source minus the first, with ca_out = (second unsigned >= first). A first source of 0xFFFFFFFF_828F3F98 and a second source of 0x828F3F68 give 0xFFFFFFD0 with carry 0.
- R9: With the overflow-enable bit set, the register subtract raises ov_en. ov_out is set when the signed 32-bit difference is out of range. so_out is so_in OR the new overflow. Without the bit, ov_en and ov_out are 0 and so_out equals so_in.
- R10: When cr_en is high, cr_out = {lt, gt, eq, so}. Exactly one of lt, gt and eq is set, from the signed 32-bit result, and so equals so_out. When cr_en is low, cr_out is 0. When ca_en is low, ca_out is 0.
- R11: Outputs change on the rising clock edge after the input is accepted. out_valid follows in_valid with one cycle of delay. While out_valid is low, all enables are low. Reset (synchronous, active high) clears out_valid and all enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation is valid |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| wb_idx | output | 5 | Destination register index |
| wb_en | output | 1 | Writeback enable |
| wb_data | output | 64 | Zero-extended writeback value |
| ca_en | output | 1 | Carry update enable |
| ca_out | output | 1 | Carry flag |
| ov_en | output | 1 | Overflow and summary-overflow update enable |
| ov_out | output | 1 | Overflow flag |
| so_out | output | 1 | Summary overflow after update |
| cr_en | output | 1 | Condition field update enable |
| cr_out | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The register subtract can update overflow and record the condition field in the same cycle. The summary-overflow bit of the condition field must then carry the overflow produced by that same instruction, not the older so_in. The bench sweeps every combination of overflow-enable and record bits over operand pairs that cross the signed boundary, with so_in toggled, and compares cr_out[0] and so_out with a model that computes the true difference in 64-bit signed arithmetic. Carry and writeback are checked in the same transactions, with random upper source halves.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 16;
  localparam int CR_W    = 4;

  localparam logic [5:0] OPC_ADDI    = 6'd14;
  localparam logic [5:0] OPC_ADDIC   = 6'd12;
  localparam logic [5:0] OPC_ADDIC_R = 6'd13;
  localparam logic [5:0] OPC_SUBFIC  = 6'd8;
  localparam logic [5:0] OPC_MULLI   = 6'd7;
  localparam logic [5:0] OPC_REGOPS  = 6'd31;
  localparam logic [8:0] XO_SUBFC    = 9'd8;

  typedef enum logic [2:0] {
    OP_NONE, OP_ADDI, OP_ADDIC, OP_SUBFIC, OP_MULLI, OP_SUBFC
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             rec;
    logic             oe;
    logic             zero_a;
    logic [IDX_W-1:0] rd;
  } dec_t;
endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
  import imm_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [5:0] opc;
  logic       unused_rb;

  assign opc       = instr[31:26];
  assign unused_rb = ^instr[15:11];

  always_comb begin
    dec        = '0;
    dec.op     = OP_NONE;
    dec.rd     = instr[25:21];
    unique case (opc)
      OPC_ADDI: begin
        dec.op     = OP_ADDI;
        dec.zero_a = (instr[20:16] == '0);
      end
      OPC_ADDIC:   dec.op = OP_ADDIC;
      OPC_ADDIC_R: begin
        dec.op  = OP_ADDIC;
        dec.rec = 1'b1;
      end
      OPC_SUBFIC:  dec.op = OP_SUBFIC;
      OPC_MULLI:   dec.op = OP_MULLI;
      OPC_REGOPS: begin
        if (instr[9:1] == XO_SUBFC) begin
          dec.op  = OP_SUBFC;
          dec.oe  = instr[10];
          dec.rec = instr[0];
        end
      end
      default: dec.op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/imm_alu_arith.sv
module imm_alu_arith
  import imm_alu_pkg::*;
#(
  parameter int WLEN = 32
) (
  input  dec_t             dec,
  input  logic [WLEN-1:0]  a,
  input  logic [WLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm16,
  output logic [WLEN-1:0]  res,
  output logic             ca,
  output logic             ov
);
  logic [WLEN-1:0] imm;
  logic [WLEN-1:0] a_eff;

  assign imm   = {{(WLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign a_eff = dec.zero_a ? '0 : a;

  always_comb begin
    res = '0;
    ca  = 1'b0;
    ov  = 1'b0;
    unique case (dec.op)
      OP_ADDI: res = a_eff + imm;
      OP_ADDIC: begin
        res = a + imm;
        ca  = (res < a);
      end
      OP_SUBFIC: begin
        res = imm - a;
        ca  = (imm >= a);
      end
      OP_MULLI: res = a * imm;
      OP_SUBFC: begin
        res = b - a;
        ca  = (b >= a);
        ov  = dec.oe & (a[WLEN-1] != b[WLEN-1]) & (res[WLEN-1] != b[WLEN-1]);
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/imm_alu_cond.sv
module imm_alu_cond
  import imm_alu_pkg::*;
#(
  parameter int WLEN = 32
) (
  input  logic [WLEN-1:0] res,
  input  logic            so_next,
  output logic [CR_W-1:0] cr
);
  logic lt, eq, gt;

  assign lt = res[WLEN-1];
  assign eq = (res == '0);
  assign gt = ~lt & ~eq;
  assign cr = {lt, gt, eq, so_next};
endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
  import imm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [XLEN-1:0]      src_a,
  input  logic [XLEN-1:0]      src_b,
  input  logic                 so_in,
  output logic                 out_valid,
  output logic [IDX_W-1:0]     wb_idx,
  output logic                 wb_en,
  output logic [XLEN-1:0]      wb_data,
  output logic                 ca_en,
  output logic                 ca_out,
  output logic                 ov_en,
  output logic                 ov_out,
  output logic                 so_out,
  output logic                 cr_en,
  output logic [CR_W-1:0]      cr_out
);
  localparam int HI_W = XLEN - WLEN;

  dec_t            dec;
  logic [WLEN-1:0] res;
  logic            ca, ov;
  logic            n_wb, n_ca, n_ov, n_cr, so_next;
  logic [CR_W-1:0] cr;
  logic            unused_hi;

  assign unused_hi = ^{src_a[XLEN-1:WLEN], src_b[XLEN-1:WLEN]};

  imm_alu_decode u_dec (.instr(instr), .dec(dec));

  imm_alu_arith #(.WLEN(WLEN)) u_arith (
    .dec(dec), .a(src_a[WLEN-1:0]), .b(src_b[WLEN-1:0]),
    .imm16(instr[IMM_W-1:0]), .res(res), .ca(ca), .ov(ov)
  );

  assign n_wb    = in_valid & (dec.op != OP_NONE);
  assign n_ca    = in_valid & (dec.op inside {OP_ADDIC, OP_SUBFIC, OP_SUBFC});
  assign n_ov    = in_valid & (dec.op == OP_SUBFC) & dec.oe;
  assign n_cr    = in_valid & (dec.op != OP_NONE) & dec.rec;
  assign so_next = so_in | (n_ov & ov);

  imm_alu_cond #(.WLEN(WLEN)) u_cond (.res(res), .so_next(so_next), .cr(cr));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      ca_en     <= 1'b0;
      ov_en     <= 1'b0;
      cr_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      ca_out    <= 1'b0;
      ov_out    <= 1'b0;
      so_out    <= 1'b0;
      cr_out    <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= n_wb;
      ca_en     <= n_ca;
      ov_en     <= n_ov;
      cr_en     <= n_cr;
      wb_idx    <= dec.rd;
      wb_data   <= {{HI_W{1'b0}}, res};
      ca_out    <= n_ca & ca;
      ov_out    <= n_ov & ov;
      so_out    <= so_next;
      cr_out    <= n_cr ? cr : '0;
    end
  end

  // R11: output strobe trails the input strobe by one cycle
  a_r11_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(wb_en | ca_en | ov_en | cr_en));
  // R1: no flag update without a decoded writeback
  a_r1_undecoded_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wb_en) |-> !(ca_en | ov_en | cr_en));
  // R3: the upper half of the writeback stays clear
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data[XLEN-1:WLEN] == '0));
  // R9: a new overflow is reflected in the summary bit
  a_r9_sticky_so: assert property (@(posedge clk) disable iff (rst)
    (ov_en && ov_out) |-> so_out);
  // R10: exactly one relation bit and a matching summary bit
  a_r10_cr_onehot: assert property (@(posedge clk) disable iff (rst)
    cr_en |-> ($countones(cr_out[3:1]) == 1));
  a_r10_cr_so: assert property (@(posedge clk) disable iff (rst)
    cr_en |-> (cr_out[0] == so_out));
endmodule

// File: tb/imm_alu_exec_tb.sv
`timescale 1ns/1ps
module imm_alu_exec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        so_in = 1'b0;
  logic        out_valid, wb_en, ca_en, ca_out, ov_en, ov_out, so_out, cr_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic [3:0]  cr_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  imm_alu_exec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .so_in(so_in), .out_valid(out_valid),
    .wb_idx(wb_idx), .wb_en(wb_en), .wb_data(wb_data), .ca_en(ca_en),
    .ca_out(ca_out), .ov_en(ov_en), .ov_out(ov_out), .so_out(so_out),
    .cr_en(cr_en), .cr_out(cr_out)
  );

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // kind: 0 addi, 1 addic, 2 addic rec, 3 subfic, 4 mulli, 5 subfc, 6 undecoded
  task automatic run(input int kind, input logic [4:0] rd, input logic [4:0] ra,
                     input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                     input logic oe, input logic rc, input logic so, input string tag);
    logic [31:0] r, i32;
    logic [32:0] wide;
    longint sa, sb, si, d, p;
    logic e_wb, e_ca, e_caen, e_ov, e_oven, e_so, e_cren;
    logic [3:0] e_cr;
    logic [63:0] got, exp;
    si = longint'($signed(imm));
    i32 = si[31:0];
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0; e_wb = 1'b1; e_ca = 1'b0; e_caen = 1'b0; e_ov = 1'b0; e_oven = 1'b0; e_cren = 1'b0;
    case (kind)
      0: begin
        instr = {6'd14, rd, ra, imm};
        r = ((ra == 5'd0) ? 32'd0 : a) + i32;
      end
      1, 2: begin
        instr = {(kind == 1) ? 6'd12 : 6'd13, rd, ra, imm};
        wide = {1'b0, a} + {1'b0, i32};
        r = wide[31:0]; e_ca = wide[32]; e_caen = 1'b1; e_cren = (kind == 2);
      end
      3: begin
        instr = {6'd8, rd, ra, imm};
        wide = {1'b0, i32} + {1'b0, ~a} + 33'd1;
        r = wide[31:0]; e_ca = wide[32]; e_caen = 1'b1;
      end
      4: begin
        instr = {6'd7, rd, ra, imm};
        p = sa * si;
        r = p[31:0];
      end
      5: begin
        instr = {6'd31, rd, ra, imm[15:11], oe, 9'd8, rc};
        wide = {1'b0, b} + {1'b0, ~a} + 33'd1;
        r = wide[31:0]; e_ca = wide[32]; e_caen = 1'b1;
        d = sb - sa;
        e_oven = oe;
        e_ov = oe & ((d > 64'sd2147483647) || (d < -64'sd2147483648));
        e_cren = rc;
      end
      default: begin
        instr = {6'd31, rd, ra, imm[15:11], oe, 9'd40, rc};
        e_wb = 1'b0;
      end
    endcase
    e_so = so | e_ov;
    e_cr = e_cren ? {($signed(r) < 0), ($signed(r) > 0), (r == 0), e_so} : 4'd0;
    src_a = {rnd(), a};
    src_b = {rnd(), b};
    so_in = so;
    in_valid = 1'b1;
    @(negedge clk);
    got = {out_valid, wb_en, ca_en, ca_out, ov_en, ov_out, so_out, cr_en, cr_out, 3'd0, wb_idx};
    exp = {1'b1, e_wb, e_caen, e_ca, e_oven, e_ov, e_so, e_cren, e_cr, 3'd0, rd};
    checks++;
    if (got !== exp || wb_data !== {32'd0, r}) begin
      errors++;
      $display("FAIL %s kind=%0d a=%h b=%h imm=%h flags act=%h exp=%h data act=%h exp=%h",
               tag, kind, a, b, imm, got, exp, wb_data, {32'd0, r});
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    automatic logic [31:0] av[12] = '{32'h0, 32'h1, 32'h5, 32'h7FFF_FFFF, 32'h8000_0000,
      32'hFFFF_FFFF, 32'h828F_3F98, 32'h828F_3F68, 32'h0001_0000, 32'h0000_7FFF,
      32'hFFFF_8000, 32'h8000_0001};
    automatic logic [15:0] iv[8] = '{16'h0, 16'h1, 16'h2, 16'hFFFF, 16'h7FFF,
      16'h8000, 16'h4000, 16'hFFFE};
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if ({out_valid, wb_en, ca_en, ov_en, cr_en} !== 5'b0) begin
      errors++;
      $display("FAIL R11 reset act=%b exp=00000", {out_valid, wb_en, ca_en, ov_en, cr_en});
    end
    rst = 1'b0;
    @(negedge clk);

    // named corner cases
    src_a = 64'hDEAD_BEEF_0000_1234;
    run(0, 5'd3, 5'd0, 32'h0000_1234, 32'h0, 16'hFFFF, 0, 0, 0, "R2 literal zero");
    run(1, 5'd4, 5'd3, 32'h0000_0001, 32'h0, 16'hFFFF, 0, 0, 0, "R4 carry case");
    run(3, 5'd4, 5'd3, 32'h5, 32'h0, 16'hFFFF, 0, 0, 0, "R6 subtract case");
    run(4, 5'd4, 5'd3, 32'h8000_0000, 32'h0, 16'h0002, 0, 0, 0, "R7 wrap case");
    run(5, 5'd5, 5'd3, 32'h828F_3F98, 32'h828F_3F68, 16'h2000, 0, 1, 0, "R8 incident case");
    run(6, 5'd7, 5'd1, 32'h9, 32'h3, 16'h0, 1, 1, 1, "R1 undecoded xo");

    // R1: undecoded primary opcode
    instr = {6'd15, 5'd2, 5'd1, 16'h1};
    @(negedge clk);
    checks++;
    if ({out_valid, wb_en, ca_en, ov_en, cr_en} !== 5'b10000 || wb_data !== 64'd0) begin
      errors++;
      $display("FAIL R1 undecoded primary act=%b/%h exp=10000/0",
               {out_valid, wb_en, ca_en, ov_en, cr_en}, wb_data);
    end

    // R2 R3 R4 R5 R6 R7: immediate forms swept over operand corners
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 8; j++)
          run(k, 5'(i + j), 5'(i + k), av[i], 32'h0, iv[j], 0, 0, 1'(i ^ j),
              k == 0 ? "R2 R3" : k == 1 ? "R4 R3" : k == 2 ? "R5 R10" : k == 3 ? "R6 R3" : "R7 R3");

    // R8 R9 R10: register subtract with every overflow-enable/record pairing
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run(5, 5'(j), 5'(i), av[i], av[j], 16'h0, m[0], m[1], m[2], "R8 R9 R10");

    // R11: idle input drops strobe and enables
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if ({out_valid, wb_en, ca_en, ov_en, cr_en} !== 5'b0) begin
      errors++;
      $display("FAIL R11 idle act=%b exp=00000", {out_valid, wb_en, ca_en, ov_en, cr_en});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule